// File: doc/BRIEF.md
# Two-Level Global-History Branch Direction Predictor

This block guesses, at fetch time, whether a conditional branch will be taken. It keeps a table of 2-bit entries. Each entry is a small state machine that holds a direction and a confidence bit. The confidence bit records whether the last guess made from that entry was correct. The table row is chosen by low fetch-address bits, with the byte-offset bits dropped. A short global history of recent branch outcomes then picks one of several entry sets inside that row.

The fetch side presents a PC and, in the same cycle, gets back a direction guess and the history value used to form it. It carries that history value along with the branch. When the branch resolves in execute, the pipeline returns the PC, the real outcome and the carried history on the update port. The block then trains the entry that made the guess and shifts the outcome into the global history. Target prediction, history repair after squashes and the pipeline itself lie outside this block.

Top module: `branch_dir_predictor`

## Requirements
- R1: Synchronous active-high reset puts every entry into the not-taken, last-guess-correct state and clears the history to zero. After reset, every PC under every history value predicts not-taken.
- R2: `pred_taken` is a combinational function of `fetch_pc` and the current history. It changes within the same cycle as `fetch_pc`, with no clock edge.
- R3: Bits [1:0] of `fetch_pc` and `upd_pc` do not take part in selecting the entry.
- R4: The entry is selected by `{history, pc[11:2]}`. The history value selects one of four independent entries for the same PC row.
- R5: One misprediction from a last-guess-correct state keeps the predicted direction and marks the entry as last-guess-wrong.
- R6: A second consecutive misprediction flips the direction, and the entry enters the new direction in the last-guess-correct state. A single later misprediction therefore does not flip it back.
- R7: A correct outcome in a last-guess-wrong state restores the last-guess-correct state and keeps the direction.
- R8: Each update with `upd_valid` high shifts `upd_taken` into history bit 0, and the old bit 0 moves to bit 1. `pred_hist` always shows the current history.
- R9: While `upd_valid` is low, neither the table nor the history changes, whatever the other update inputs carry.
- R10: An update trains the entry selected by `{upd_hist, upd_pc[11:2]}`, not the entry selected by the current history.
- R11: When a fetch lookup and an update hit the same entry in the same cycle, the lookup returns the value the entry held before that update.
- R12: PCs that differ only in bits above bit 11 share entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_pc | input | 32 | Address being fetched |
| pred_taken | output | 1 | Direction guess for `fetch_pc` (1 = taken) |
| pred_hist | output | 2 | Global history used for the guess; bit 0 is the newest outcome |
| upd_valid | input | 1 | A resolved branch is presented on the update port |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome (1 = taken) |
| upd_hist | input | 2 | History value that was returned when the branch was predicted |

## Verification
The bound checker follows the history register on every cycle. It checks that history clears on reset, that it shifts exactly the resolved outcome in on each valid update, and that it holds still when no update arrives. It also checks that a guess cannot change without an update while the fetch address is held. The two-mistake hysteresis, the selection by the returned history rather than the live one, aliasing across high PC bits and the old-value result of a same-entry collision all depend on entry contents that the ports do not expose. Only the bench's training sequences, which steer the history back onto a chosen set before reading it, can show them.

// File: rtl/bp_pkg.sv
package bp_pkg;

    // Bit 1: predicted direction (1 = taken). Bit 0: last guess was correct.
    typedef enum logic [1:0] {
        NT_WRONG = 2'b00,
        NT_RIGHT = 2'b01,
        TK_WRONG = 2'b10,
        TK_RIGHT = 2'b11
    } bp_state_e;

    localparam bp_state_e BP_RESET_STATE = NT_RIGHT;

    function automatic logic bp_dir(input bp_state_e s);
        return s[1];
    endfunction

    // Two-mistake hysteresis: the direction changes only on a miss while already marked wrong.
    function automatic bp_state_e bp_next(input bp_state_e s, input logic taken);
        bp_state_e n;
        unique case (s)
            NT_RIGHT: n = taken ? NT_WRONG : NT_RIGHT;
            NT_WRONG: n = taken ? TK_RIGHT : NT_RIGHT;
            TK_RIGHT: n = taken ? TK_RIGHT : TK_WRONG;
            TK_WRONG: n = taken ? TK_RIGHT : NT_RIGHT;
            default:  n = BP_RESET_STATE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/bp_index.sv
module bp_index #(
    parameter int PC_W      = 32,
    parameter int OFF_BITS  = 2,
    parameter int ROW_BITS  = 10,
    parameter int HIST_BITS = 2,
    localparam int IDX_W    = HIST_BITS + ROW_BITS
) (
    input  logic [PC_W-1:0]      pc,
    input  logic [HIST_BITS-1:0] hist,
    output logic [IDX_W-1:0]     idx
);
    logic unused_pc_bits;
    assign unused_pc_bits = ^{pc[PC_W-1:OFF_BITS+ROW_BITS], pc[OFF_BITS-1:0]};

    // History forms the upper index bits, so it picks the set within a PC row.
    assign idx = {hist, pc[OFF_BITS +: ROW_BITS]};
endmodule

// File: rtl/bp_history.sv
module bp_history #(
    parameter int HIST_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 shift_en,
    input  logic                 outcome,
    output logic [HIST_BITS-1:0] hist
);
    logic [HIST_BITS-1:0] hist_q;
    logic [HIST_BITS-1:0] hist_shifted;

    generate
        if (HIST_BITS == 1) begin : g_single
            assign hist_shifted = outcome;
        end else begin : g_multi
            assign hist_shifted = {hist_q[HIST_BITS-2:0], outcome};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            hist_q <= '0;
        else if (shift_en)
            hist_q <= hist_shifted;
    end

    assign hist = hist_q;
endmodule

// File: rtl/bp_table.sv
module bp_table
    import bp_pkg::*;
#(
    parameter int IDX_W     = 12,
    localparam int ENTRIES  = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    bp_state_e entry_q [ENTRIES];
    bp_state_e wr_cur;

    assign wr_cur   = entry_q[wr_idx];
    // The read path sees registered contents only, so a same-cycle write is not visible yet.
    assign rd_taken = bp_dir(entry_q[rd_idx]);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++)
                entry_q[i] <= BP_RESET_STATE;
        end else if (wr_en) begin
            entry_q[wr_idx] <= bp_next(wr_cur, wr_taken);
        end
    end
endmodule

// File: rtl/branch_dir_predictor.sv
module branch_dir_predictor #(
    parameter int PC_W      = 32,
    parameter int OFF_BITS  = 2,
    parameter int ROW_BITS  = 10,
    parameter int HIST_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PC_W-1:0]      fetch_pc,
    output logic                 pred_taken,
    output logic [HIST_BITS-1:0] pred_hist,
    input  logic                 upd_valid,
    input  logic [PC_W-1:0]      upd_pc,
    input  logic                 upd_taken,
    input  logic [HIST_BITS-1:0] upd_hist
);
    localparam int IDX_W = HIST_BITS + ROW_BITS;

    logic [HIST_BITS-1:0] ghr;
    logic [IDX_W-1:0]     fetch_idx;
    logic [IDX_W-1:0]     train_idx;

    bp_history #(.HIST_BITS(HIST_BITS)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (upd_valid),
        .outcome  (upd_taken),
        .hist     (ghr)
    );

    bp_index #(
        .PC_W(PC_W), .OFF_BITS(OFF_BITS), .ROW_BITS(ROW_BITS), .HIST_BITS(HIST_BITS)
    ) u_fetch_idx (
        .pc   (fetch_pc),
        .hist (ghr),
        .idx  (fetch_idx)
    );

    bp_index #(
        .PC_W(PC_W), .OFF_BITS(OFF_BITS), .ROW_BITS(ROW_BITS), .HIST_BITS(HIST_BITS)
    ) u_train_idx (
        .pc   (upd_pc),
        .hist (upd_hist),
        .idx  (train_idx)
    );

    bp_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (fetch_idx),
        .rd_taken (pred_taken),
        .wr_en    (upd_valid),
        .wr_idx   (train_idx),
        .wr_taken (upd_taken)
    );

    assign pred_hist = ghr;
endmodule

// File: rtl/branch_dir_predictor_chk.sv
module branch_dir_predictor_chk #(
    parameter int PC_W      = 32,
    parameter int HIST_BITS = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic [PC_W-1:0]      fetch_pc,
    input logic                 pred_taken,
    input logic [HIST_BITS-1:0] pred_hist,
    input logic                 upd_valid,
    input logic                 upd_taken
);
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    p_reset_hist_r1: assert property (@(posedge clk) rst |=> pred_hist == '0);

    p_hist_newest_r8: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> pred_hist[0] == $past(upd_taken));

    generate
        if (HIST_BITS > 1) begin : g_older
            p_hist_age_r8: assert property (@(posedge clk) disable iff (rst)
                upd_valid |=> pred_hist[HIST_BITS-1:1] == $past(pred_hist[HIST_BITS-2:0]));
        end
    endgenerate

    p_hist_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(pred_hist));

    p_guess_stable_r9: assert property (@(posedge clk) disable iff (rst || !armed)
        (!$past(upd_valid) && $stable(fetch_pc)) |-> $stable(pred_taken));
endmodule

bind branch_dir_predictor branch_dir_predictor_chk #(
    .PC_W(PC_W), .HIST_BITS(HIST_BITS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fetch_pc   (fetch_pc),
    .pred_taken (pred_taken),
    .pred_hist  (pred_hist),
    .upd_valid  (upd_valid),
    .upd_taken  (upd_taken)
);

// File: tb/sim_branch_dir_predictor.sv
module sim_branch_dir_predictor;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] fetch_pc;
    logic        pred_taken;
    logic [1:0]  pred_hist;
    logic        upd_valid;
    logic [31:0] upd_pc;
    logic        upd_taken;
    logic [1:0]  upd_hist;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    branch_dir_predictor u0 (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
        .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .upd_hist(upd_hist)
    );

    localparam logic [15:0] PA = 16'h0100; // trained branch
    localparam logic [15:0] PZ = 16'h0200; // scratch branch used to steer history
    localparam logic [15:0] PB = 16'h1100; // aliases PA above bit 11
    localparam logic [15:0] PO = 16'h0103; // PA with offset bits set

    // {upd_valid, upd_pc, upd_taken, upd_hist, fetch_pc, exp_taken, exp_hist, req}
    localparam int NV = 25;
    localparam logic [42:0] VEC [NV] = '{
        {1'b0, 16'h0, 1'b0, 2'd0, PA, 1'b0, 2'd0, 4'd1 },  // R1 fresh table
        {1'b1, PA,    1'b1, 2'd0, PA, 1'b0, 2'd0, 4'd5 },  // R5 first miss
        {1'b1, PZ,    1'b0, 2'd1, PA, 1'b0, 2'd1, 4'd8 },  // R8
        {1'b1, PZ,    1'b0, 2'd2, PA, 1'b0, 2'd2, 4'd8 },  // R8
        {1'b0, 16'h0, 1'b0, 2'd0, PA, 1'b0, 2'd0, 4'd5 },  // R5 no flip yet
        {1'b1, PA,    1'b1, 2'd0, PA, 1'b0, 2'd0, 4'd6 },  // R6 second miss
        {1'b1, PZ,    1'b0, 2'd1, PA, 1'b0, 2'd1, 4'd4 },  // R4 other set
        {1'b1, PZ,    1'b0, 2'd2, PA, 1'b0, 2'd2, 4'd4 },  // R4
        {1'b0, 16'h0, 1'b0, 2'd0, PO, 1'b1, 2'd0, 4'd3 },  // R3 R6 flipped
        {1'b1, PA,    1'b0, 2'd0, PB, 1'b1, 2'd0, 4'd12},  // R12 alias
        {1'b0, 16'h0, 1'b0, 2'd0, PA, 1'b1, 2'd0, 4'd6 },  // R6 one miss keeps
        {1'b1, PA,    1'b1, 2'd0, PA, 1'b1, 2'd0, 4'd7 },  // R7 restore
        {1'b1, PZ,    1'b0, 2'd1, PA, 1'b0, 2'd1, 4'd4 },  // R4
        {1'b1, PZ,    1'b0, 2'd2, PA, 1'b0, 2'd2, 4'd4 },  // R4
        {1'b1, PA,    1'b0, 2'd0, PA, 1'b1, 2'd0, 4'd11},  // R11 old value
        {1'b1, PA,    1'b0, 2'd0, PA, 1'b1, 2'd0, 4'd7 },  // R7 still taken
        {1'b0, 16'h0, 1'b0, 2'd0, PA, 1'b0, 2'd0, 4'd6 },  // R6 flip back
        {1'b1, PA,    1'b1, 2'd3, PA, 1'b0, 2'd0, 4'd10},  // R10 train set 3
        {1'b1, PA,    1'b1, 2'd3, PA, 1'b0, 2'd1, 4'd10},  // R10
        {1'b0, 16'h0, 1'b0, 2'd0, PA, 1'b1, 2'd3, 4'd10},  // R10 set 3 taken
        {1'b1, PZ,    1'b0, 2'd3, PA, 1'b1, 2'd3, 4'd8 },  // R8
        {1'b1, PZ,    1'b0, 2'd2, PA, 1'b0, 2'd2, 4'd8 },  // R8
        {1'b0, 16'h0, 1'b0, 2'd0, PA, 1'b0, 2'd0, 4'd10},  // R10 set 0 untouched
        {1'b0, PA,    1'b1, 2'd0, PA, 1'b0, 2'd0, 4'd9 },  // R9 inactive update
        {1'b0, 16'h0, 1'b0, 2'd0, PA, 1'b0, 2'd0, 4'd9 }   // R9 nothing moved
    };

    task automatic check(input int req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic uv, input logic [15:0] upc, input logic ut,
                        input logic [1:0] uh, input logic [15:0] fpc);
        @(negedge clk);
        upd_valid = uv;
        upd_pc    = {16'h0, upc};
        upd_taken = ut;
        upd_hist  = uh;
        fetch_pc  = {16'h0, fpc};
        #5;
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; upd_valid = 1'b0; upd_pc = '0; upd_taken = 1'b0;
        upd_hist = '0; fetch_pc = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][42], VEC[i][41:26], VEC[i][25], VEC[i][24:23], VEC[i][22:7]);
            check(int'(VEC[i][3:0]), "prediction", {31'b0, pred_taken}, {31'b0, VEC[i][6]});
            check(int'(VEC[i][3:0]), "history", {30'b0, pred_hist}, {30'b0, VEC[i][5:4]});
        end

        // R10: steer history to 3 and read the set trained with upd_hist = 3
        step(1'b1, PZ, 1'b1, 2'd0, PA);
        step(1'b1, PZ, 1'b1, 2'd1, PA);
        step(1'b0, 16'h0, 1'b0, 2'd0, PA);
        check(10, "trained set 3", {31'b0, pred_taken}, 32'd1);
        check(8, "history after two taken", {30'b0, pred_hist}, 32'd3);

        // R1: reset in mid-run clears history and entries
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #5;
        check(1, "history after reset", {30'b0, pred_hist}, 32'd0);
        step(1'b1, PZ, 1'b1, 2'd0, PA);
        step(1'b1, PZ, 1'b1, 2'd1, PA);
        step(1'b0, 16'h0, 1'b0, 2'd0, PA);
        check(1, "set 3 cleared by reset", {31'b0, pred_taken}, 32'd0);

        // R2: guess follows fetch_pc with no clock edge
        step(1'b1, PA, 1'b1, 2'd3, PA);
        step(1'b1, PA, 1'b1, 2'd3, PA);
        step(1'b0, 16'h0, 1'b0, 2'd0, PA);
        check(2, "trained PC", {31'b0, pred_taken}, 32'd1);
        fetch_pc = {16'h0, PZ};
        #2;
        check(2, "combinational switch", {31'b0, pred_taken}, 32'd0);
        fetch_pc = {16'h0, PA};
        #2;
        check(2, "combinational switch back", {31'b0, pred_taken}, 32'd1);

        done = 1'b1;
        finish_run();
    end
endmodule